// File: doc/BRIEF.md
# Fail-Safe Clock Monitor

This block watches the running system clock against an always-on, low-power reference clock and catches the moment the system clock stops. The monitored clock drives a small divider whose top bit is an activity flag. That flag crosses into the reference domain through a two-flop synchroniser, and an edge detector there turns each change into an activity event. If no activity event is seen for a set number of reference cycles, the block declares a clock failure.

On a failure it sends one trap pulse and sets a sticky clock-fail flag. It also tells the clock switch controller to move to the fast internal RC oscillator. The forced source code depends on the PLL setting in use at the moment of failure: if the PLL was scaling the system clock, the fast RC is driven through the PLL; otherwise the plain fast RC is chosen. A valid software-started clock switch clears the flag and opens a guard window, so a planned handover is not reported as a failure.

The block only monitors when both the monitor-enable and the clock-switch-enable configuration bits are set and the device is awake. Under those same conditions it asks for the reference oscillator to run, whatever the watchdog is doing.

Top module: `clkmon_failsafe`

## Requirements
- R1: After reset, `trap_o`, `clk_fail_o` and `force_sel_o` are 0 and `force_src_o` holds the plain fast-RC code 3'b000.
- R2: While the monitored clock keeps toggling, with the activity flag changing at least once per TIMEOUT-2 reference cycles, no failure is declared.
- R3: Once the monitored clock stops, a failure is declared after TIMEOUT consecutive reference cycles with no observed activity. The trap appears between TIMEOUT-2 and TIMEOUT+8 reference cycles after the stop.
- R4: `trap_o` is high for exactly one reference cycle for each failure.
- R5: In the cycle the trap rises, `clk_fail_o` and `force_sel_o` are set. They stay set, with no further trap, until a switch start.
- R6: On failure, `force_src_o` becomes 3'b001 (fast RC through the PLL) if `cur_pll_i` was high, and 3'b000 (plain fast RC) if it was low.
- R7: A pulse on `switch_start_i` clears `clk_fail_o` and `force_sel_o` in the next reference cycle.
- R8: For GUARD reference cycles after a switch start, no failure is declared even if the monitored clock is stopped. After that window, a stopped clock is detected again.
- R9: While `sleep_i` is high, no failure is declared. When `sleep_i` falls with the clock still stopped, a failure follows within TIMEOUT+8 cycles.
- R10: `ref_run_o` equals `cfg_fscm_en_i & cfg_switch_en_i & ~sleep_i`.
- R11: If either `cfg_fscm_en_i` or `cfg_switch_en_i` is low, a stopped monitored clock raises no trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref_i | input | 1 | Low-power reference clock; all control logic runs on it |
| clk_mon_i | input | 1 | Monitored system clock |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| cfg_fscm_en_i | input | 1 | Configuration: monitor enable |
| cfg_switch_en_i | input | 1 | Configuration: clock switching enable |
| sleep_i | input | 1 | Device is in sleep mode |
| cur_pll_i | input | 1 | The PLL currently scales the system clock |
| switch_start_i | input | 1 | One-cycle pulse: a valid software clock switch begins |
| ref_run_o | output | 1 | Keep the reference oscillator running |
| trap_o | output | 1 | One-cycle clock-failure trap request |
| clk_fail_o | output | 1 | Sticky clock-fail status |
| force_sel_o | output | 1 | Tells the switch controller to use `force_src_o` |
| force_src_o | output | SRC_W | Forced source code: 0 = fast RC, 1 = fast RC with PLL |

## Verification
The bench builds the block with TIMEOUT=6, GUARD=16 and DIV_W=2. The 10 ns monitored clock then flips the activity flag every 2.5 reference cycles, well inside the timeout, so a running clock is clearly distinguished from a stopped one. The short timeout and guard let every failure, the guard window, and the sleep and disable suspensions be exercised many times within a few thousand cycles. The detection latency window is checked from both sides.

// File: rtl/cfm_pkg.sv
package cfm_pkg;

    localparam int SRC_W = 3;
    localparam logic [SRC_W-1:0] SRC_FRC    = 3'b000;
    localparam logic [SRC_W-1:0] SRC_FRCPLL = 3'b001;

    // Reference-domain control state, sized for the widest counters allowed.
    typedef struct packed {
        logic [15:0]      idle;
        logic [15:0]      guard;
        logic             fail;
        logic             trap;
        logic [SRC_W-1:0] src;
    } ctl_t;

endpackage

// File: rtl/cfm_activity_src.sv
// Monitored-domain activity flag: flips every 2**(DIV_W-1) edges (every edge when DIV_W is 0).
module cfm_activity_src #(
    parameter int DIV_W = 2
) (
    input  logic clk_mon_i,
    input  logic rst_ni,
    output logic flag_o
);
    generate
        if (DIV_W == 0) begin : g_plain
            logic tog_q;
            always_ff @(posedge clk_mon_i or negedge rst_ni) begin
                if (!rst_ni) tog_q <= 1'b0;
                else         tog_q <= ~tog_q;
            end
            assign flag_o = tog_q;
        end else begin : g_div
            logic [DIV_W-1:0] cnt_q;
            always_ff @(posedge clk_mon_i or negedge rst_ni) begin
                if (!rst_ni) cnt_q <= '0;
                else         cnt_q <= cnt_q + 1'b1;
            end
            assign flag_o = cnt_q[DIV_W-1];
        end
    endgenerate
endmodule

// File: rtl/cfm_sync_edge.sv
// Two-flop synchroniser into the reference domain, plus change detection.
module cfm_sync_edge (
    input  logic clk_ref_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic change_o
);
    logic s1_q, s2_q, s3_q;

    always_ff @(posedge clk_ref_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= async_i;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign change_o = s2_q ^ s3_q;
endmodule

// File: rtl/clkmon_failsafe.sv
module clkmon_failsafe #(
    parameter int TIMEOUT = 8,
    parameter int GUARD   = 32,
    parameter int DIV_W   = 2,
    parameter int SRC_W   = cfm_pkg::SRC_W
) (
    input  logic             clk_ref_i,
    input  logic             clk_mon_i,
    input  logic             rst_ni,
    input  logic             cfg_fscm_en_i,
    input  logic             cfg_switch_en_i,
    input  logic             sleep_i,
    input  logic             cur_pll_i,
    input  logic             switch_start_i,
    output logic             ref_run_o,
    output logic             trap_o,
    output logic             clk_fail_o,
    output logic             force_sel_o,
    output logic [SRC_W-1:0] force_src_o
);
    import cfm_pkg::*;

    localparam logic [15:0] IDLE_LAST  = 16'(TIMEOUT - 1);
    localparam logic [15:0] GUARD_LOAD = 16'(GUARD);

    logic act_flag;
    logic activity;
    logic enabled;
    logic monitoring;
    logic fire;
    ctl_t ctl_d, ctl_q;

    cfm_activity_src #(.DIV_W(DIV_W)) u_src (
        .clk_mon_i (clk_mon_i),
        .rst_ni    (rst_ni),
        .flag_o    (act_flag)
    );

    cfm_sync_edge u_sync (
        .clk_ref_i (clk_ref_i),
        .rst_ni    (rst_ni),
        .async_i   (act_flag),
        .change_o  (activity)
    );

    assign enabled = cfg_fscm_en_i & cfg_switch_en_i;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.trap = 1'b0;
        monitoring = enabled && !sleep_i && !switch_start_i
                     && (ctl_q.guard == '0) && !ctl_q.fail;
        fire       = monitoring && !activity && (ctl_q.idle == IDLE_LAST);

        // Guard window after a planned switch.
        if (switch_start_i)          ctl_d.guard = GUARD_LOAD;
        else if (ctl_q.guard != '0)  ctl_d.guard = ctl_q.guard - 1'b1;

        // Count reference cycles without activity.
        if (!monitoring || activity || fire) ctl_d.idle = '0;
        else                                 ctl_d.idle = ctl_q.idle + 1'b1;

        if (switch_start_i) begin
            ctl_d.fail = 1'b0;
        end else if (fire) begin
            ctl_d.fail = 1'b1;
            ctl_d.trap = 1'b1;
            ctl_d.src  = cur_pll_i ? SRC_FRCPLL : SRC_FRC;
        end
    end

    always_ff @(posedge clk_ref_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q     <= '0;
            ctl_q.src <= SRC_FRC;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ref_run_o   = enabled & ~sleep_i;
    assign trap_o      = ctl_q.trap;
    assign clk_fail_o  = ctl_q.fail;
    assign force_sel_o = ctl_q.fail;
    assign force_src_o = ctl_q.src[SRC_W-1:0];
endmodule

// File: rtl/cfm_checker.sv
module cfm_checker (
    input logic clk_ref_i,
    input logic rst_ni,
    input logic cfg_fscm_en_i,
    input logic cfg_switch_en_i,
    input logic sleep_i,
    input logic switch_start_i,
    input logic trap_o,
    input logic clk_fail_o,
    input logic force_sel_o
);
    // R4: trap is a single-cycle pulse
    a_r4_trap_single: assert property (@(posedge clk_ref_i) disable iff (!rst_ni)
        trap_o |=> !trap_o);

    // R5: a new fail flag always comes with the trap
    a_r5_fail_with_trap: assert property (@(posedge clk_ref_i) disable iff (!rst_ni)
        $rose(clk_fail_o) |-> (trap_o && force_sel_o));

    // R5: no further trap while the flag is set
    a_r5_no_retrap: assert property (@(posedge clk_ref_i) disable iff (!rst_ni)
        clk_fail_o |=> !trap_o);

    // R7: switch start clears the flag
    a_r7_switch_clears: assert property (@(posedge clk_ref_i) disable iff (!rst_ni)
        switch_start_i |=> (!clk_fail_o && !force_sel_o));

    // R8: no trap directly after a switch start
    a_r8_guard_start: assert property (@(posedge clk_ref_i) disable iff (!rst_ni)
        trap_o |-> !$past(switch_start_i));

    // R9 / R11: trap only follows an awake, enabled cycle
    a_r9_trap_when_active: assert property (@(posedge clk_ref_i) disable iff (!rst_ni)
        trap_o |-> $past(cfg_fscm_en_i && cfg_switch_en_i && !sleep_i));
endmodule

bind clkmon_failsafe cfm_checker u_cfm_checker (
    .clk_ref_i       (clk_ref_i),
    .rst_ni          (rst_ni),
    .cfg_fscm_en_i   (cfg_fscm_en_i),
    .cfg_switch_en_i (cfg_switch_en_i),
    .sleep_i         (sleep_i),
    .switch_start_i  (switch_start_i),
    .trap_o          (trap_o),
    .clk_fail_o      (clk_fail_o),
    .force_sel_o     (force_sel_o)
);

// File: tb/sim_clkmon_failsafe.sv
`timescale 1ns/1ps
module sim_clkmon_failsafe;
    localparam int TIMEOUT = 6;
    localparam int GUARD   = 16;
    localparam int DIV_W   = 2;

    logic       clk_ref = 1'b0;
    logic       clk_mon = 1'b0;
    logic       mon_run = 1'b1;
    logic       rst_n = 1'b0;
    logic       cfg_en = 1'b1, cfg_sw = 1'b1, sleep = 1'b0, cur_pll = 1'b0, sw_start = 1'b0;
    logic       ref_run, trap, clk_fail, force_sel;
    logic [2:0] force_src;
    int         checks = 0, errors = 0;
    bit         done = 1'b0;

    always #4 clk_ref = ~clk_ref;
    always begin
        #5;
        if (mon_run) clk_mon = ~clk_mon;
    end

    clkmon_failsafe #(.TIMEOUT(TIMEOUT), .GUARD(GUARD), .DIV_W(DIV_W)) u0 (
        .clk_ref_i(clk_ref), .clk_mon_i(clk_mon), .rst_ni(rst_n),
        .cfg_fscm_en_i(cfg_en), .cfg_switch_en_i(cfg_sw), .sleep_i(sleep),
        .cur_pll_i(cur_pll), .switch_start_i(sw_start), .ref_run_o(ref_run),
        .trap_o(trap), .clk_fail_o(clk_fail), .force_sel_o(force_sel),
        .force_src_o(force_src)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk_ref);
    endtask

    // Counts cycles until trap is seen; returns -1 if none within limit.
    task automatic wait_trap(input int limit, output int cyc);
        cyc = -1;
        for (int i = 1; i <= limit; i++) begin
            step(1);
            if (trap) begin
                cyc = i;
                break;
            end
        end
    endtask

    task automatic quiet(input int n, output int traps);
        traps = 0;
        for (int i = 0; i < n; i++) begin
            step(1);
            if (trap) traps++;
        end
    endtask

    task automatic switch_pulse();
        sw_start = 1'b1;
        step(1);
        sw_start = 1'b0;
    endtask

    task automatic t_reset();
        check(trap == 1'b0, "R1 trap", trap, 0);
        check(clk_fail == 1'b0, "R1 clk_fail", clk_fail, 0);
        check(force_sel == 1'b0, "R1 force_sel", force_sel, 0);
        check(force_src == 3'b000, "R1 force_src", force_src, 0);
    endtask

    task automatic t_alive();
        int n;
        quiet(300, n);
        check(n == 0, "R2 running clock traps", n, 0);
        check(clk_fail == 1'b0, "R2 running clock flag", clk_fail, 0);
    endtask

    task automatic t_fail(input bit pll, input int exp_src);
        int c, n;
        cur_pll = pll;
        mon_run = 1'b0;
        wait_trap(TIMEOUT + 8, c);
        check(c >= TIMEOUT - 2 && c <= TIMEOUT + 8, "R3 detect latency", c, TIMEOUT);
        check(clk_fail == 1'b1, "R5 flag with trap", clk_fail, 1);
        check(force_sel == 1'b1, "R5 force_sel with trap", force_sel, 1);
        check(force_src == 3'(exp_src), "R6 forced source", force_src, exp_src);
        step(1);
        check(trap == 1'b0, "R4 trap width", trap, 0);
        cur_pll = ~pll;
        quiet(60, n);
        check(n == 0, "R5 no retrap", n, 0);
        check(clk_fail == 1'b1 && force_sel == 1'b1, "R5 flag sticky", clk_fail, 1);
        check(force_src == 3'(exp_src), "R6 source held", force_src, exp_src);
    endtask

    task automatic t_clear();
        mon_run = 1'b1;
        switch_pulse();
        check(clk_fail == 1'b0, "R7 flag cleared", clk_fail, 1'b0);
        check(force_sel == 1'b0, "R7 force_sel cleared", force_sel, 0);
        step(GUARD + 4);
    endtask

    task automatic t_guard();
        int n, c;
        mon_run = 1'b0;
        switch_pulse();
        quiet(GUARD - 1, n);
        check(n == 0, "R8 guard window", n, 0);
        wait_trap(TIMEOUT + 10, c);
        check(c > 0, "R8 detect after guard", c, TIMEOUT);
        mon_run = 1'b1;
        switch_pulse();
        step(GUARD + 4);
    endtask

    task automatic t_sleep();
        int n, c;
        sleep = 1'b1;
        step(1);
        check(ref_run == 1'b0, "R10 ref_run in sleep", ref_run, 0);
        mon_run = 1'b0;
        quiet(100, n);
        check(n == 0, "R9 no trap in sleep", n, 0);
        check(clk_fail == 1'b0, "R9 no flag in sleep", clk_fail, 0);
        sleep = 1'b0;
        step(1);
        check(ref_run == 1'b1, "R10 ref_run awake", ref_run, 1);
        wait_trap(TIMEOUT + 8, c);
        check(c > 0, "R9 detect after wake", c, TIMEOUT);
        mon_run = 1'b1;
        switch_pulse();
        step(GUARD + 4);
    endtask

    task automatic t_disabled(input bit en, input bit sw);
        int n;
        cfg_en = en;
        cfg_sw = sw;
        step(1);
        check(ref_run == 1'b0, "R10 ref_run disabled", ref_run, 0);
        mon_run = 1'b0;
        quiet(100, n);
        check(n == 0, "R11 no trap when disabled", n, 0);
        check(clk_fail == 1'b0, "R11 no flag when disabled", clk_fail, 0);
        mon_run = 1'b1;
        step(10);
        cfg_en = 1'b1;
        cfg_sw = 1'b1;
        step(10);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(2);
        t_reset();
        t_alive();
        t_fail(1'b0, 0);
        t_clear();
        t_alive();
        t_fail(1'b1, 1);
        t_clear();
        t_guard();
        t_sleep();
        t_disabled(1'b1, 1'b0);
        t_disabled(1'b0, 1'b1);
        t_alive();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (50000) @(posedge clk_ref);
                checks++;
                errors++;
                $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule